// File: doc/BRIEF.md
# Frame-Inclusive Sample Parity Checker

This block watches a dual-port parallel sample stream. Each sample carries two data words and a frame/parity bit, and the frame/parity bit shares a pin with the frame function. The block folds the frame bit and every bit of both words into one parity value. It then compares that value against a selectable even or odd rule and reports each mismatch.

The check runs only under two conditions. The parity enable must be set, and the two-bit pin-function field must choose parity use. Once those hold, every strobed sample is checked, for as long as the stream runs. A mismatch produces a one-cycle registered pulse and sets a sticky flag, and it is counted in a saturating counter. A single clear pulse empties both the flag and the counter.

Top module: `frame_parity_chk`

## Requirements
- R1: The parity of a sample is the XOR of the frame bit, all bits of the port-0 word and all bits of the port-1 word, taken as one group.
- R2: With `odd_sel` = 0 (even rule), a checked sample is a mismatch when the group XOR equals 1.
- R3: With `odd_sel` = 1 (odd rule), a checked sample is a mismatch when the group XOR equals 0.
- R4: A sample is checked only when `par_en` = 1 and `pin_mode` equals 2'b01. Any other mode value, or `par_en` = 0, yields no pulse, no flag change and no count change.
- R5: A sample presented with `smp_valid` = 0 is ignored. It yields no pulse, no flag change and no count change.
- R6: `err_flag` rises on the first mismatch and stays high until a clear pulse.
- R7: An `err_clr` cycle zeroes `err_flag` and `err_count`. A mismatch in that same cycle is still recorded, leaving the flag at 1 and the count at 1.
- R8: `err_count` increases by exactly one per mismatch.
- R9: `err_count` saturates at its all-ones value and does not wrap.
- R10: `err_pulse`, `err_flag` and `err_count` reflect a sample on the clock edge that captures it (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_en | input | 1 | Parity feature enable |
| pin_mode | input | 2 | Pin-function field; 2'b01 selects parity use |
| odd_sel | input | 1 | 0 = even rule, 1 = odd rule |
| smp_valid | input | 1 | Sample strobe |
| frame_bit | input | 1 | Frame/parity bit of the sample |
| port0_data | input | W_WORD | Port-0 data word |
| port1_data | input | W_WORD | Port-1 data word |
| err_clr | input | 1 | Clears the flag and the counter |
| err_pulse | output | 1 | One-cycle mismatch indication |
| err_flag | output | 1 | Sticky mismatch flag |
| err_count | output | W_CNT | Saturating mismatch count |

## Verification
The bench keeps the word width at its default of 14 bits, so the parity group stays at the full 29 bits. It reduces the counter width to 4 bits, which lets saturation at 15 and the hold that follows it be reached within a few dozen mismatches. Random samples stress every bit position of the group under both rules. Directed cases single out each gating condition and the coincidence of a clear with a mismatch.

// File: rtl/frame_parity_chk.sv
module frame_parity_chk #(
  parameter int W_WORD   = 14,
  parameter int W_CNT    = 16,
  parameter logic [1:0] MODE_PAR = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_en,
  input  logic [1:0]        pin_mode,
  input  logic              odd_sel,
  input  logic              smp_valid,
  input  logic              frame_bit,
  input  logic [W_WORD-1:0] port0_data,
  input  logic [W_WORD-1:0] port1_data,
  input  logic              err_clr,
  output logic              err_pulse,
  output logic              err_flag,
  output logic [W_CNT-1:0]  err_count
);
  localparam logic [W_CNT-1:0] CNT_MAX = '1;

  logic group_xor, check_on, mismatch;

  assign group_xor = frame_bit ^ (^port0_data) ^ (^port1_data);
  assign check_on  = par_en && (pin_mode == MODE_PAR) && smp_valid;
  assign mismatch  = check_on && (group_xor != odd_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_flag  <= 1'b0;
      err_count <= '0;
    end else begin
      err_pulse <= mismatch;
      err_flag  <= mismatch || (err_flag && !err_clr);
      if (err_clr)
        err_count <= mismatch ? W_CNT'(1) : '0;
      else if (mismatch && err_count != CNT_MAX)
        err_count <= err_count + 1'b1;
    end
  end

  a_r4_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_en && pin_mode == MODE_PAR && smp_valid) |=> !err_pulse);
  a_r6_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_flag);
  a_r7_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (err_flag == err_pulse));
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));
  a_r9_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !err_clr) |=> err_count == CNT_MAX);
endmodule

// File: tb/frame_parity_chk_tb.sv
module frame_parity_chk_tb;
  localparam int W_WORD = 14;
  localparam int W_CNT  = 4;

  logic clk = 0, rst_n = 0;
  logic par_en = 0, odd_sel = 0, smp_valid = 0, frame_bit = 0, err_clr = 0;
  logic [1:0] pin_mode = 0;
  logic [W_WORD-1:0] p0 = 0, p1 = 0;
  logic err_pulse, err_flag;
  logic [W_CNT-1:0] err_count;

  int checks = 0, errors = 0;
  logic e_pulse = 0, e_flag = 0;
  logic [W_CNT-1:0] e_cnt = 0;

  always #5 clk = ~clk;

  frame_parity_chk #(.W_WORD(W_WORD), .W_CNT(W_CNT)) u_dut (
    .clk(clk), .rst_n(rst_n), .par_en(par_en), .pin_mode(pin_mode), .odd_sel(odd_sel),
    .smp_valid(smp_valid), .frame_bit(frame_bit), .port0_data(p0), .port1_data(p1),
    .err_clr(err_clr), .err_pulse(err_pulse), .err_flag(err_flag), .err_count(err_count));

  function automatic logic grp(logic f, logic [W_WORD-1:0] a, logic [W_WORD-1:0] b);
    logic x = f;
    for (int i = 0; i < W_WORD; i++) x = x ^ a[i] ^ b[i];
    return x;
  endfunction

  task automatic chk(string tag);
    checks++;
    if (err_pulse !== e_pulse || err_flag !== e_flag || err_count !== e_cnt) begin
      errors++;
      $display("FAIL %s: got pulse=%0b flag=%0b cnt=%0d exp pulse=%0b flag=%0b cnt=%0d",
               tag, err_pulse, err_flag, err_count, e_pulse, e_flag, e_cnt);
    end
  endtask

  task automatic step(logic en, logic [1:0] md, logic od, logic v, logic f,
                      logic [W_WORD-1:0] a, logic [W_WORD-1:0] b, logic clr, string tag);
    logic mm;
    @(negedge clk);
    par_en = en; pin_mode = md; odd_sel = od; smp_valid = v; frame_bit = f;
    p0 = a; p1 = b; err_clr = clr;
    mm = en && md == 2'b01 && v && (grp(f, a, b) != od);
    @(posedge clk); #1;
    e_pulse = mm;
    e_flag  = mm || (e_flag && !clr);
    if (clr) e_cnt = mm ? 1 : 0;
    else if (mm && e_cnt != '1) e_cnt = e_cnt + 1;
    chk(tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12; chk("R10 reset state");
    rst_n = 1;
    step(1, 2'b01, 0, 1, 0, 14'h0000, 14'h0000, 0, "R2 even clean");
    step(1, 2'b01, 0, 1, 1, 14'h0000, 14'h0000, 0, "R1 frame bit counted");
    step(1, 2'b01, 0, 1, 0, 14'h2000, 14'h0000, 0, "R1 port0 msb counted");
    step(1, 2'b01, 0, 1, 0, 14'h0000, 14'h0001, 0, "R1 port1 lsb counted");
    step(1, 2'b01, 1, 1, 0, 14'h0000, 14'h0000, 0, "R3 odd mismatch");
    step(1, 2'b01, 1, 1, 1, 14'h0000, 14'h0000, 0, "R3 odd clean, R6 flag stays");
    step(0, 2'b01, 0, 1, 1, 14'h0000, 14'h0000, 0, "R4 enable off");
    step(1, 2'b00, 0, 1, 1, 14'h0000, 14'h0000, 0, "R4 mode 0");
    step(1, 2'b10, 0, 1, 1, 14'h0000, 14'h0000, 0, "R4 mode 2");
    step(1, 2'b11, 0, 1, 1, 14'h0000, 14'h0000, 0, "R4 mode 3");
    step(1, 2'b01, 0, 0, 1, 14'h0000, 14'h0000, 0, "R5 no strobe");
    step(1, 2'b01, 0, 1, 0, 14'h0000, 14'h0000, 1, "R7 clear");
    step(1, 2'b01, 0, 1, 1, 14'h0000, 14'h0000, 1, "R7 clear with mismatch");
    for (int i = 0; i < 20; i++)
      step(1, 2'b01, 0, 1, 1, 14'h3fff, 14'h0000, 0, "R8 R9 count to saturation");
    step(1, 2'b01, 0, 1, 0, 14'h0000, 14'h0000, 1, "R7 clear after saturation");
    for (int i = 0; i < 3000; i++) begin
      logic clr = ($urandom % 40) == 0;
      step($urandom % 8 != 0, ($urandom % 4 == 0) ? 2'($urandom) : 2'b01, 1'($urandom),
           $urandom % 6 != 0, 1'($urandom), 14'($urandom), 14'($urandom), clr,
           "R1 R2 R3 R6 R10 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule